// File: doc/BRIEF.md
# Quadrant Direction-Flag Status Logic for a Dual-Clock FIFO

This block produces the full and empty flags of a dual-clock FIFO. Its inputs are the Gray-coded write and read pointers, each PTR_W bits wide and with no extra wrap bit. The two top bits of each pointer name one of four quadrants of the buffer, taken in the cyclic order 00, 01, 11, 10.

A direction bit records whether the buffer was last moving toward full or toward empty. The bit is set when the write quadrant sits one step before the read quadrant. It is cleared when the write quadrant sits one step after the read quadrant. The bit is a level-sensitive latch driven straight from the pointer comparison, so it belongs to neither clock.

When the two pointers are equal, the direction bit decides the flag. A direction of "toward full" gives full, and "toward empty" gives empty. The writer sees full in its own domain and the reader sees empty in its own domain. Each flag rises at once when the condition appears. Each flag falls only after two edges of its own clock, so the flags err on the safe side. The storage array and the pointer counters sit outside this block.

Top module: `afifo_quad_status`

## Requirements
- R1: When the write quadrant is the one that precedes the read quadrant in the order 00→01→11→10→00, the direction bit becomes "toward full". Whenever the pointers are then equal, full is raised.
- R2: When the write quadrant is the one that follows the read quadrant in that order, the direction bit becomes "toward empty". Whenever the pointers are then equal, empty is raised.
- R3: With the FIFO driven as a normal queue of depth 2**PTR_W, and every flag given three edges of each clock to settle, full is high exactly when the occupancy equals the depth.
- R4: Under the same conditions as R3, empty is high exactly when the occupancy is zero.
- R5: While either reset is low, the direction bit is "toward empty". After reset with equal pointers, empty=1 and full=0.
- R6: Full rises combinationally, in the same time step as the write pointer change that makes the pointers equal. It does not wait for any write-clock edge.
- R7: Once the full condition goes away, full stays high through the first write-clock edge and falls after the second.
- R8: Empty rises combinationally on the read pointer change that makes the pointers equal. Once the condition goes away, empty stays high through one read-clock edge and falls after the second.
- R9: When the quadrants are equal or opposite, the direction bit keeps its value. A queue drained from full to half depth and then refilled shows full again. A queue filled from empty to half depth and then drained shows empty again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low, released in step with wclk |
| wr_gray | input | PTR_W | Write pointer, Gray coded |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low, released in step with rclk |
| rd_gray | input | PTR_W | Read pointer, Gray coded |
| wr_full | output | 1 | Full flag, seen by the writer |
| rd_empty | output | 1 | Empty flag, seen by the reader |

## Verification
The properties assume that each pointer moves by at most one Gray step at a time. They also assume that the writer never advances while full is high and the reader never advances while empty is high. Under those rules the occupancy stays between zero and the depth, and the quadrant distance never skips a step.

The bench plays both ends of the queue with its own binary counters and converts them to Gray. It moves a pointer only when its model occupancy allows the move. It changes pointers at times that never coincide with an edge of either clock, so the latch and the release stages see clean transitions.

// File: rtl/afifo_quad_pkg.sv
`timescale 1ns/1ps
package afifo_quad_pkg;

  typedef logic [1:0] quad_t;

  // Quadrant that follows q in the cyclic Gray order 00 -> 01 -> 11 -> 10.
  function automatic quad_t quad_succ(input quad_t q);
    quad_t s;
    case (q)
      2'b00:   s = 2'b01;
      2'b01:   s = 2'b11;
      2'b11:   s = 2'b10;
      default: s = 2'b00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/quad_dir_latch.sv
`timescale 1ns/1ps
module quad_dir_latch
  import afifo_quad_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             rst_any_n,
  input  logic [PTR_W-1:0] wr_gray,
  input  logic [PTR_W-1:0] rd_gray,
  output logic             dir_full
);
  localparam int QHI = PTR_W - 1;
  localparam int QLO = PTR_W - 2;

  quad_t wq, rq;
  logic  head_to_full, head_to_empty;

  always_comb begin
    wq            = wr_gray[QHI:QLO];
    rq            = rd_gray[QHI:QLO];
    head_to_full  = (quad_succ(wq) == rq);
    head_to_empty = (quad_succ(rq) == wq);
  end

  // Level-sensitive set/clear; reset and "toward empty" take precedence.
  always_latch begin
    if (!rst_any_n || head_to_empty)
      dir_full = 1'b0;
    else if (head_to_full)
      dir_full = 1'b1;
  end

endmodule

// File: rtl/flag_release_sync.sv
`timescale 1ns/1ps
module flag_release_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flag_o
);
  logic [STAGES-1:0] hold_q, hold_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb hold_d = raw_i;
    end else begin : g_chain
      always_comb hold_d = {hold_q[STAGES-2:0], raw_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= {STAGES{RST_VAL}};
    else        hold_q <= hold_d;
  end

  // Immediate assertion from raw, release only after the chain empties.
  always_comb flag_o = raw_i | (|hold_q);

endmodule

// File: rtl/afifo_quad_status.sv
`timescale 1ns/1ps
module afifo_quad_status #(
  parameter int PTR_W      = 4,
  parameter int REL_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic [PTR_W-1:0] wr_gray,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic [PTR_W-1:0] rd_gray,
  output logic             wr_full,
  output logic             rd_empty
);
  logic rst_any_n;
  logic dir_going_full;
  logic ptr_same;
  logic full_raw, empty_raw;

  always_comb begin
    rst_any_n = wrst_n & rrst_n;
    ptr_same  = (wr_gray == rd_gray);
    full_raw  = ptr_same &  dir_going_full;
    empty_raw = ptr_same & ~dir_going_full;
  end

  quad_dir_latch #(.PTR_W(PTR_W)) u_dir (
    .rst_any_n (rst_any_n),
    .wr_gray   (wr_gray),
    .rd_gray   (rd_gray),
    .dir_full  (dir_going_full)
  );

  flag_release_sync #(.STAGES(REL_STAGES), .RST_VAL(1'b0)) u_full_sync (
    .clk    (wclk),
    .rst_n  (wrst_n),
    .raw_i  (full_raw),
    .flag_o (wr_full)
  );

  flag_release_sync #(.STAGES(REL_STAGES), .RST_VAL(1'b1)) u_empty_sync (
    .clk    (rclk),
    .rst_n  (rrst_n),
    .raw_i  (empty_raw),
    .flag_o (rd_empty)
  );

endmodule

// File: rtl/afifo_quad_status_chk.sv
`timescale 1ns/1ps
module afifo_quad_status_chk #(
  parameter int PTR_W = 4
) (
  input logic             wclk,
  input logic             rclk,
  input logic             wrst_n,
  input logic             rrst_n,
  input logic [PTR_W-1:0] wr_gray,
  input logic [PTR_W-1:0] rd_gray,
  input logic             dir_full,
  input logic             wr_full,
  input logic             rd_empty
);
  logic [1:0] wq_b, rq_b;
  logic       w_behind, w_ahead, same_ptr;

  // Quadrant index in binary (Gray to binary on two bits), distance mod 4.
  always_comb begin
    wq_b     = {wr_gray[PTR_W-1], wr_gray[PTR_W-1] ^ wr_gray[PTR_W-2]};
    rq_b     = {rd_gray[PTR_W-1], rd_gray[PTR_W-1] ^ rd_gray[PTR_W-2]};
    w_behind = (2'(wq_b + 2'd1) == rq_b);
    w_ahead  = (2'(rq_b + 2'd1) == wq_b);
    same_ptr = (wr_gray == rd_gray);
  end

  a_r1_dir_set: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
    w_behind |-> dir_full);

  a_r2_dir_clear: assert property (@(posedge rclk) disable iff (!wrst_n || !rrst_n)
    w_ahead |-> !dir_full);

  a_r6_full_when_equal: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
    (same_ptr && dir_full) |-> wr_full);

  a_r8_empty_when_equal: assert property (@(posedge rclk) disable iff (!wrst_n || !rrst_n)
    (same_ptr && !dir_full) |-> rd_empty);

  a_r7_full_release: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
    $fell(wr_full) |-> $past(!(same_ptr && dir_full)));

  a_r8_empty_release: assert property (@(posedge rclk) disable iff (!wrst_n || !rrst_n)
    $fell(rd_empty) |-> $past(!(same_ptr && !dir_full)));

endmodule

bind afifo_quad_status afifo_quad_status_chk #(.PTR_W(PTR_W)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .wrst_n   (wrst_n),
  .rrst_n   (rrst_n),
  .wr_gray  (wr_gray),
  .rd_gray  (rd_gray),
  .dir_full (dir_going_full),
  .wr_full  (wr_full),
  .rd_empty (rd_empty)
);

// File: tb/afifo_quad_status_tb.sv
`timescale 1ns/1ps
module afifo_quad_status_tb;
  localparam int PTR_W = 4;
  localparam int DEPTH = 1 << PTR_W;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n, rrst_n;
  logic [PTR_W-1:0] wbin, rbin, wr_gray, rd_gray;
  logic wr_full, rd_empty;
  int   occ;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #2 wclk = ~wclk;   // 250 MHz
  always #3 rclk = ~rclk;

  always_comb begin
    wr_gray = wbin ^ (wbin >> 1);
    rd_gray = rbin ^ (rbin >> 1);
  end

  afifo_quad_status #(.PTR_W(PTR_W)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_gray(wr_gray),
    .rclk(rclk), .rrst_n(rrst_n), .rd_gray(rd_gray),
    .wr_full(wr_full), .rd_empty(rd_empty)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s occ=%0d actual=%0b expected=%0b", tag, occ, act, exp);
    end
  endtask

  // Pointer moves land on odd/even times that never meet a clock edge.
  task automatic do_write();
    @(negedge wclk);
    wbin = wbin + 1'b1;
    occ++;
  endtask

  task automatic do_read();
    @(negedge rclk);
    #1;
    rbin = rbin + 1'b1;
    occ--;
  endtask

  task automatic settle();
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    #0.5;
  endtask

  task automatic check_settled(input string tag);
    settle();
    chk(wr_full,  (occ == DEPTH), {tag, " R3 full"});
    chk(rd_empty, (occ == 0),     {tag, " R4 empty"});
  endtask

  task automatic apply_reset();
    wrst_n = 1'b0; rrst_n = 1'b0;
    wbin = '0; rbin = '0; occ = 0;
    #20;
    @(negedge wclk); wrst_n = 1'b1;
    @(negedge rclk); rrst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    apply_reset();
    settle();
    chk(wr_full,  1'b0, "R5 full after reset");
    chk(rd_empty, 1'b1, "R5 empty after reset");

    // R8: empty release timing, then immediate re-assertion
    do_write();
    #0.5 chk(rd_empty, 1'b1, "R8 empty held at write");
    @(posedge rclk); #0.5 chk(rd_empty, 1'b1, "R8 empty after 1 rclk");
    @(posedge rclk); #0.5 chk(rd_empty, 1'b0, "R8 empty after 2 rclk");
    do_read();
    #0.5 chk(rd_empty, 1'b1, "R8 empty immediate on read");
    check_settled("R2 idle");

    // Sweep of full fill/drain cycles at several pointer offsets
    for (int round = 0; round < 5; round++) begin
      while (occ < DEPTH) begin
        do_write();
        #0.5;
        if (occ == DEPTH) chk(wr_full, 1'b1, "R6 full immediate");
        check_settled("R1 fill");
      end
      if (round == 0) begin
        do_read();
        #0.5 chk(wr_full, 1'b1, "R7 full held at read");
        @(posedge wclk); #0.5 chk(wr_full, 1'b1, "R7 full after 1 wclk");
        @(posedge wclk); #0.5 chk(wr_full, 1'b0, "R7 full after 2 wclk");
      end
      while (occ > 0) begin
        do_read();
        check_settled("R2 drain");
      end
      for (int k = 0; k <= round; k++) begin
        do_write();
        do_read();
      end
      check_settled("R4 offset shift");
    end

    // R9: opposite quadrant keeps the direction
    while (occ < DEPTH) do_write();
    check_settled("R9 full");
    repeat (DEPTH / 2) do_read();
    check_settled("R9 half from full");
    repeat (DEPTH / 2) do_write();
    settle(); chk(wr_full, 1'b1, "R9 refill to full");
    while (occ > 0) do_read();
    check_settled("R9 empty");
    repeat (DEPTH / 2) do_write();
    check_settled("R9 half from empty");
    repeat (DEPTH / 2) do_read();
    settle(); chk(rd_empty, 1'b1, "R9 drain to empty");

    // Oscillation at both boundaries
    while (occ < DEPTH - 1) do_write();
    for (int k = 0; k < 4; k++) begin
      do_write(); check_settled("R3 near full up");
      do_read();  check_settled("R3 near full down");
    end
    while (occ > 1) do_read();
    for (int k = 0; k < 4; k++) begin
      do_read();  check_settled("R4 near empty down");
      do_write(); check_settled("R4 near empty up");
    end

    // R5: reset in mid-flight returns to the empty state
    apply_reset();
    settle();
    chk(wr_full,  1'b0, "R5 full after second reset");
    chk(rd_empty, 1'b1, "R5 empty after second reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule